// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drives frame transmission from a ring of buffer descriptors kept in system memory. Software builds descriptors, points the block at the first one through a ring base load, and then pulses an activation strobe. The engine fetches each descriptor, copies the referenced buffer bytes into a local frame store, hands the descriptor back to software with its ready bit cleared, and signals per-buffer and per-frame events. It goes on until it fetches a descriptor that software has not marked ready.

A frame may be split across several descriptors. Bytes are collected until a descriptor carrying the last flag is consumed, and only then is the whole frame sent on a byte stream with start and end markers. A frame that would grow beyond the configured maximum is cut short and flagged as a babbling transmit. A descriptor with the wrap flag sends the walk back to the ring base. Clearing the enable input stops the walk, discards any half-collected frame and rewinds to the ring base.

Each descriptor takes two 32-bit words. The word at the descriptor address carries the byte count in bits 15:0 and the flags in bits 31:16. Within the flags, ready is bit 15 (word bit 31), wrap is bit 13 (word bit 29) and last is bit 11 (word bit 27). The word at address plus 4 holds the byte address of the buffer.

Top module: `tx_desc_ring`

## Requirements
- R1: A fetched descriptor whose ready bit (word bit 31) is clear ends the walk without being consumed, and the next activation fetches that same descriptor address first.
- R2: Bytes of consecutive descriptors form one frame until a descriptor with the last flag (word bit 27) is consumed. The frame then leaves as one burst, with the start marker on its first byte and the end marker on its last. A frame with no bytes produces no stream output.
- R3: When the collected length plus a descriptor's count would exceed FRAME_MAX, only the remaining room is copied, and a babble event pulses for that descriptor.
- R4: Every consumed descriptor gives one transmit-buffer event pulse. A consumed descriptor with the last flag also gives a transmit-frame event pulse in the same cycle.
- R5: Each consumed descriptor has its first word written back with bit 31 cleared and every other bit unchanged. Its buffer-address word is not written.
- R6: After a descriptor is consumed, the next descriptor address is the ring base when the wrap flag (word bit 29) is set, and otherwise the current address plus 8.
- R7: An activation strobe while enable_i is low starts no memory access.
- R8: A low level on enable_i returns the current descriptor address to the ring base and discards any partially collected frame.
- R9: A ring base load stores the given address with bits 1:0 forced to zero, reads it back on base_o, and makes it the current descriptor address.
- R10: Buffer bytes are sent in increasing address order. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a with bits 1:0 cleared, so buffers may start at any byte address.
- R11: A frame left incomplete when the walk stops stays pending, and the bytes of later descriptors are appended to it on a later activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable level |
| activate_i | input | 1 | One-cycle strobe that starts a ring walk |
| base_load_i | input | 1 | Load strobe for the ring base |
| base_i | input | AW | Ring base address to load |
| base_o | output | AW | Stored ring base |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sop_o | output | 1 | First byte of frame |
| tx_eop_o | output | 1 | Last byte of frame |
| ev_txb_o | output | 1 | Transmit-buffer event pulse |
| ev_txf_o | output | 1 | Transmit-frame event pulse |
| ev_babble_o | output | 1 | Babbling-transmit event pulse |

## Verification
Random rings of one to five descriptors, with random byte counts, last flags and unaligned buffer pointers, exercise frame joining and byte order. The acknowledge latency on the memory side is also random. A few long counts push frames past FRAME_MAX, which separates a correct clip of the remaining room from an overrun or a dropped descriptor. Directed rings check three further cases. A walk that stops on a not-ready descriptor and then resumes shows that both the address and the pending bytes are kept. A walk cut by an enable drop shows that both are discarded. An activation while disabled must produce no memory traffic at all. After every walk, the order of the descriptor fetches and the written-back descriptor words are compared with a bench model. This tells apart wrap handling, address advance and ready-bit clearing.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  localparam int LEN_W      = 16;
  localparam int DESC_BYTES = 8;
  // positions inside the first descriptor word (flags live in [31:16])
  localparam int RDY_BIT  = 31;
  localparam int WRAP_BIT = 29;
  localparam int LAST_BIT = 27;

  typedef enum logic [2:0] {
    W_IDLE,
    W_CTRL,
    W_PTR,
    W_BYTE,
    W_COMMIT,
    W_DRAIN,
    W_WBACK
  } walk_st_e;
endpackage

// File: rtl/tx_frame_buf.sv
module tx_frame_buf #(
  parameter int FRAME_MAX = 64,
  localparam int FL_W = $clog2(FRAME_MAX + 1),
  localparam int IW   = $clog2(FRAME_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            push_i,
  input  logic [7:0]      push_data_i,
  input  logic            commit_i,
  output logic [FL_W-1:0] fill_o,
  output logic            busy_o,
  output logic            tx_valid_o,
  output logic [7:0]      tx_data_o,
  output logic            tx_sop_o,
  output logic            tx_eop_o
);
  localparam logic [FL_W-1:0] CAP = FL_W'(FRAME_MAX);

  logic [7:0]      store_q [FRAME_MAX];
  logic [FL_W-1:0] fill_q, send_len_q, idx_q;
  logic            sending_q;
  logic            room_ok;

  assign room_ok = fill_q < CAP;

  always_ff @(posedge clk_i) begin
    if (push_i && room_ok) store_q[fill_q[IW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q     <= '0;
      send_len_q <= '0;
      idx_q      <= '0;
      sending_q  <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
      tx_sop_o   <= 1'b0;
      tx_eop_o   <= 1'b0;
    end else if (flush_i) begin
      fill_q     <= '0;
      sending_q  <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_sop_o   <= 1'b0;
      tx_eop_o   <= 1'b0;
    end else begin
      tx_valid_o <= 1'b0;
      tx_sop_o   <= 1'b0;
      tx_eop_o   <= 1'b0;
      if (push_i && room_ok) fill_q <= fill_q + 1'b1;
      if (commit_i && fill_q != '0) begin
        sending_q  <= 1'b1;
        send_len_q <= fill_q;
        idx_q      <= '0;
        fill_q     <= '0;
      end
      if (sending_q) begin
        tx_valid_o <= 1'b1;
        tx_data_o  <= store_q[idx_q[IW-1:0]];
        tx_sop_o   <= idx_q == '0;
        tx_eop_o   <= idx_q == send_len_q - 1'b1;
        idx_q      <= idx_q + 1'b1;
        if (idx_q == send_len_q - 1'b1) sending_q <= 1'b0;
      end
    end
  end

  assign fill_o = fill_q;
  assign busy_o = sending_q;

  p_fill_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CAP);
  p_no_push_in_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !sending_q);
  p_burst_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_eop_o |=> !tx_valid_o);
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_desc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 64,
  localparam int FL_W = $clog2(FRAME_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enable_i,
  input  logic            activate_i,
  input  logic            base_load_i,
  input  logic [AW-1:0]   base_i,
  output logic [AW-1:0]   base_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic [31:0]     mem_rdata_i,
  input  logic            mem_ack_i,
  output logic            push_o,
  output logic [7:0]      push_data_o,
  output logic            commit_o,
  input  logic [FL_W-1:0] fill_i,
  input  logic            drain_busy_i,
  output logic            ev_txb_o,
  output logic            ev_txf_o,
  output logic            ev_babble_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  walk_st_e         st_q, after_st;
  logic [AW-1:0]    base_q, cur_q, ptr_q, base_new;
  logic [31:0]      ctrl_q;
  logic [LEN_W-1:0] left_q, copy_len;
  logic [LEN_W:0]   room_w;
  logic             bab_q, clip;
  logic             ev_txb_q, ev_txf_q, ev_bab_q;

  assign base_new = {base_i[AW-1:2], 2'b00};
  assign after_st = ctrl_q[LAST_BIT] ? W_COMMIT : W_WBACK;
  assign room_w   = (LEN_W + 1)'(FRAME_MAX) - (LEN_W + 1)'(fill_i);
  assign clip     = {1'b0, ctrl_q[LEN_W-1:0]} > room_w;
  assign copy_len = clip ? room_w[LEN_W-1:0] : ctrl_q[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= W_IDLE;
      base_q   <= '0;
      cur_q    <= '0;
      ptr_q    <= '0;
      ctrl_q   <= '0;
      left_q   <= '0;
      bab_q    <= 1'b0;
      ev_txb_q <= 1'b0;
      ev_txf_q <= 1'b0;
      ev_bab_q <= 1'b0;
    end else begin
      ev_txb_q <= 1'b0;
      ev_txf_q <= 1'b0;
      ev_bab_q <= 1'b0;
      if (!enable_i) begin
        st_q  <= W_IDLE;
        cur_q <= base_q;
      end else begin
        case (st_q)
          W_IDLE: if (activate_i) st_q <= W_CTRL;
          W_CTRL: if (mem_ack_i) begin
            ctrl_q <= mem_rdata_i;
            st_q   <= mem_rdata_i[RDY_BIT] ? W_PTR : W_IDLE;
          end
          W_PTR: if (mem_ack_i) begin
            ptr_q  <= mem_rdata_i;
            left_q <= copy_len;
            bab_q  <= clip;
            st_q   <= (copy_len == '0) ? after_st : W_BYTE;
          end
          W_BYTE: if (mem_ack_i) begin
            ptr_q  <= ptr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) st_q <= after_st;
          end
          W_COMMIT: st_q <= W_DRAIN;
          W_DRAIN:  if (!drain_busy_i) st_q <= W_WBACK;
          W_WBACK: if (mem_ack_i) begin
            ev_txb_q <= 1'b1;
            ev_txf_q <= ctrl_q[LAST_BIT];
            ev_bab_q <= bab_q;
            cur_q    <= ctrl_q[WRAP_BIT] ? base_q : cur_q + STEP;
            st_q     <= W_CTRL;
          end
          default: st_q <= W_IDLE;
        endcase
      end
      if (base_load_i) begin
        base_q <= base_new;
        cur_q  <= base_new;
      end
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = cur_q;
    case (st_q)
      W_CTRL:  mem_req_o = 1'b1;
      W_PTR: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'(4);
      end
      W_BYTE: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {ptr_q[AW-1:2], 2'b00};
      end
      W_WBACK: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (ptr_q[1:0])
      2'd0:    push_data_o = mem_rdata_i[7:0];
      2'd1:    push_data_o = mem_rdata_i[15:8];
      2'd2:    push_data_o = mem_rdata_i[23:16];
      default: push_data_o = mem_rdata_i[31:24];
    endcase
  end

  assign mem_wdata_o = {1'b0, ctrl_q[30:0]};
  assign push_o      = (st_q == W_BYTE) && mem_ack_i;
  assign commit_o    = st_q == W_COMMIT;
  assign base_o      = base_q;
  assign ev_txb_o    = ev_txb_q;
  assign ev_txf_o    = ev_txf_q;
  assign ev_babble_o = ev_bab_q;

  p_stop_not_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_CTRL && mem_ack_i && !mem_rdata_i[RDY_BIT]) |=> st_q == W_IDLE);
  p_txf_with_txb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_txf_q |-> ev_txb_q);
  p_wb_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == cur_q && !mem_wdata_o[RDY_BIT]));
  p_wrap_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_WBACK && mem_ack_i && ctrl_q[WRAP_BIT] && !base_load_i) |=> cur_q == base_q);
  p_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_WBACK && mem_ack_i && !ctrl_q[WRAP_BIT] && enable_i && !base_load_i)
    |=> cur_q == $past(cur_q) + STEP);
  p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !mem_req_o);
  p_base_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_load_i |=> base_q[1:0] == 2'b00);
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int AW        = 32,
  parameter int FRAME_MAX = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          activate_i,
  input  logic          base_load_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] base_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_sop_o,
  output logic          tx_eop_o,
  output logic          ev_txb_o,
  output logic          ev_txf_o,
  output logic          ev_babble_o
);
  localparam int FL_W = $clog2(FRAME_MAX + 1);

  logic            push, commit, busy;
  logic [7:0]      push_data;
  logic [FL_W-1:0] fill;

  tx_ring_walker #(.AW(AW), .FRAME_MAX(FRAME_MAX)) u_walker (
    .clk_i, .rst_ni, .enable_i, .activate_i, .base_load_i, .base_i, .base_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .push_o(push), .push_data_o(push_data), .commit_o(commit),
    .fill_i(fill), .drain_busy_i(busy),
    .ev_txb_o, .ev_txf_o, .ev_babble_o
  );

  tx_frame_buf #(.FRAME_MAX(FRAME_MAX)) u_frame (
    .clk_i, .rst_ni, .flush_i(!enable_i),
    .push_i(push), .push_data_i(push_data), .commit_i(commit),
    .fill_o(fill), .busy_o(busy),
    .tx_valid_o, .tx_data_o, .tx_sop_o, .tx_eop_o
  );
endmodule

// File: tb/tb_tx_desc_ring.sv
module tb_tx_desc_ring;
  localparam int AW   = 32;
  localparam int FMAX = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, enable = 1'b0, act = 1'b0, base_load = 1'b0;
  logic [AW-1:0] base_in = '0, base_out, mem_addr;
  logic          mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0]   mem_wdata, mem_rdata = '0;
  logic          tx_valid, tx_sop, tx_eop, ev_txb, ev_txf, ev_bab;
  logic [7:0]    tx_data;

  tx_desc_ring #(.AW(AW), .FRAME_MAX(FMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .activate_i(act),
    .base_load_i(base_load), .base_i(base_in), .base_o(base_out),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_sop_o(tx_sop), .tx_eop_o(tx_eop),
    .ev_txb_o(ev_txb), .ev_txf_o(ev_txf), .ev_babble_o(ev_bab)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] sh  [0:1023];
  int vectors = 0, miscmp = 0;

  logic [7:0]  got_bytes[$], exp_bytes[$], m_pend[$];
  int          got_lens[$], exp_lens[$];
  logic [31:0] act_fetch[$], exp_fetch[$];
  int cnt_txb = 0, cnt_txf = 0, cnt_bab = 0, exp_txb = 0, exp_txf = 0, exp_bab = 0;
  int cur_len = 0, sop_err = 0, req_cycles = 0;
  logic [31:0] m_cur = 0, m_base = 0;
  int unsigned lat = 0;

  // memory model with random acknowledge latency
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat != 0) lat--;
      else begin
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[11:2]];
          if (mem_addr < 32'h800 && !mem_addr[2]) act_fetch.push_back(mem_addr);
        end
        mem_ack = 1'b1;
        lat = $urandom_range(0, 2);
      end
    end
  end

  always @(negedge clk) begin
    if (mem_req) req_cycles++;
    if (ev_txb) cnt_txb++;
    if (ev_txf) cnt_txf++;
    if (ev_bab) cnt_bab++;
    if (tx_valid) begin
      got_bytes.push_back(tx_data);
      cur_len++;
      if (tx_sop != (cur_len == 1)) sop_err++;
      if (tx_eop) begin
        got_lens.push_back(cur_len);
        cur_len = 0;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string req, input string what, input longint a, input longint e);
    vectors++;
    if (a != e) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, a, e);
    end
  endtask

  function automatic logic [31:0] dword(bit rdy, bit wrap, bit last, logic [15:0] len);
    return {rdy, 1'b0, wrap, 1'b0, last, 11'd0, len};
  endfunction

  task automatic put_w(input int a, input logic [31:0] v);
    mem[a >> 2] = v;
    sh[a >> 2]  = v;
  endtask

  task automatic put_desc(input int a, input bit rdy, input bit wrap, input bit last,
                          input int len, input int ptr);
    put_w(a, dword(rdy, wrap, last, 16'(len)));
    put_w(a + 4, 32'(ptr));
  endtask

  // reference walk over the shadow memory
  task automatic model_walk();
    for (int it = 0; it < 64; it++) begin
      logic [31:0] w0, ptr, a, w;
      int len, room;
      w0 = sh[m_cur[11:2]];
      exp_fetch.push_back(m_cur);
      if (!w0[31]) break;
      ptr  = sh[(m_cur[11:2]) + 1];
      len  = int'(w0[15:0]);
      room = FMAX - m_pend.size();
      if (len > room) begin
        len = room;
        exp_bab++;
      end
      for (int i = 0; i < len; i++) begin
        a = ptr + 32'(i);
        w = sh[a[11:2]];
        m_pend.push_back(w[{a[1:0], 3'b000} +: 8]);
      end
      exp_txb++;
      if (w0[27]) begin
        exp_txf++;
        if (m_pend.size() > 0) begin
          exp_lens.push_back(m_pend.size());
          foreach (m_pend[i]) exp_bytes.push_back(m_pend[i]);
          m_pend.delete();
        end
      end
      sh[m_cur[11:2]] = w0 & 32'h7fff_ffff;
      m_cur = w0[29] ? m_base : m_cur + 32'd8;
    end
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (mem_req || tx_valid) q = 0;
      else q++;
    end
  endtask

  task automatic activate();
    @(negedge clk) act = 1'b1;
    @(negedge clk) act = 1'b0;
    model_walk();
    wait_quiet();
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk) begin base_load = 1'b1; base_in = v; end
    @(negedge clk) base_load = 1'b0;
    m_base = v & ~32'd3;
    m_cur  = m_base;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk) enable = v;
    if (!v) begin
      m_cur = m_base;
      m_pend.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic compare_run(input string name);
    int bad = 0;
    chk("R2", {name, " frame count"}, got_lens.size(), exp_lens.size());
    for (int i = 0; i < got_lens.size() && i < exp_lens.size(); i++)
      chk("R2", {name, " frame length"}, got_lens[i], exp_lens[i]);
    chk("R2", {name, " start marker placement"}, sop_err, 0);
    chk("R10", {name, " byte count"}, got_bytes.size(), exp_bytes.size());
    for (int i = 0; i < got_bytes.size() && i < exp_bytes.size(); i++)
      if (got_bytes[i] != exp_bytes[i]) bad++;
    chk("R10", {name, " byte mismatches"}, bad, 0);
    chk("R4", {name, " buffer events"}, cnt_txb, exp_txb);
    chk("R4", {name, " frame events"}, cnt_txf, exp_txf);
    chk("R3", {name, " babble events"}, cnt_bab, exp_bab);
    chk("R6", {name, " fetch count"}, act_fetch.size(), exp_fetch.size());
    bad = 0;
    for (int i = 0; i < act_fetch.size() && i < exp_fetch.size(); i++)
      if (act_fetch[i] != exp_fetch[i]) bad++;
    chk("R6", {name, " fetch order mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != sh[i]) bad++;
    chk("R5", {name, " descriptor words after writeback"}, bad, 0);
    got_bytes.delete(); exp_bytes.delete(); got_lens.delete(); exp_lens.delete();
    act_fetch.delete(); exp_fetch.delete();
    cnt_txb = 0; cnt_txf = 0; cnt_bab = 0; exp_txb = 0; exp_txf = 0; exp_bab = 0;
    sop_err = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (i >= 512) ? $urandom() : 32'd0;
      sh[i]  = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset base", base_out, 0);
    chk("R2", "reset stream valid", tx_valid, 0);
    chk("R4", "reset events", {ev_txb, ev_txf, ev_bab}, 0);
    chk("R7", "reset memory request", mem_req, 0);
    set_en(1'b1);

    // R9: base alignment and base load becomes current address
    set_base(32'h10B);
    chk("R9", "base low bits forced to zero", base_out, 32'h108);
    put_desc(32'h108, 1, 1, 1, 5, 32'h803);
    activate();
    chk("R9", "first fetch at loaded base", exp_fetch[0], 32'h108);
    compare_run("R9 base load");

    // split frame across descriptors, wrap to base
    set_base(32'h100);
    put_desc(32'h100, 1, 0, 0, 5, 32'h901);
    put_desc(32'h108, 1, 0, 1, 3, 32'h922);
    put_desc(32'h110, 1, 1, 1, 7, 32'h9A7);
    activate();
    compare_run("R2 joined frames");

    // R3: babble clip
    set_base(32'h200);
    put_desc(32'h200, 1, 0, 0, 50, 32'hA00);
    put_desc(32'h208, 1, 1, 1, 30, 32'hB01);
    activate();
    chk("R3", "clipped frame length", got_lens.size() > 0 ? got_lens[0] : 0, FMAX);
    chk("R3", "babble pulse count", cnt_bab, 1);
    compare_run("R3 babble");

    // R11 / R1: stop on not-ready, resume with pending bytes
    set_base(32'h300);
    put_desc(32'h300, 1, 0, 0, 4, 32'hC02);
    put_desc(32'h308, 0, 0, 0, 0, 32'h0);
    activate();
    chk("R11", "no frame while pending", got_lens.size(), 0);
    compare_run("R1 stop");
    put_desc(32'h308, 1, 1, 1, 2, 32'hC40);
    activate();
    chk("R1", "resume fetch address", act_fetch.size() > 0 ? act_fetch[0] : 0, 32'h308);
    chk("R11", "pending plus new bytes", got_lens.size() > 0 ? got_lens[0] : 0, 6);
    compare_run("R11 resume");

    // R8: enable drop discards pending bytes and rewinds
    set_base(32'h400);
    put_desc(32'h400, 1, 0, 0, 4, 32'hD00);
    put_desc(32'h408, 0, 0, 0, 0, 32'h0);
    activate();
    compare_run("R8 partial");
    set_en(1'b0);
    set_en(1'b1);
    put_desc(32'h400, 1, 1, 1, 3, 32'hD10);
    activate();
    chk("R8", "rewound fetch address", act_fetch.size() > 0 ? act_fetch[0] : 0, 32'h400);
    chk("R8", "partial bytes discarded", got_lens.size() > 0 ? got_lens[0] : 0, 3);
    compare_run("R8 restart");

    // R7: activation while disabled
    set_base(32'h500);
    put_desc(32'h500, 1, 1, 1, 6, 32'hE00);
    set_en(1'b0);
    req_cycles = 0;
    @(negedge clk) act = 1'b1;
    @(negedge clk) act = 1'b0;
    repeat (30) @(negedge clk);
    chk("R7", "memory requests while disabled", req_cycles, 0);
    chk("R7", "frames while disabled", got_lens.size(), 0);
    set_en(1'b1);
    activate();
    compare_run("R7 after enable");

    // random rings
    for (int r = 0; r < 24; r++) begin
      int base, k;
      base = 32'h100 * (1 + $urandom_range(0, 5));
      k = $urandom_range(1, 5);
      for (int j = 0; j < k; j++) begin
        int len;
        bit last;
        len  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(1, 23);
        last = (j == k - 1) || ($urandom_range(0, 1) == 1);
        put_desc(base + 8 * j, 1, j == k - 1, last, len, 32'h800 + $urandom_range(0, 32'h6FF));
      end
      set_base(base);
      activate();
      compare_run("random ring");
    end

    summary();
    $finish;
  end
endmodule